// File: doc/BRIEF.md
# SDRAM Burst Page Command Sequencer

This block converts a single host transfer request into the complete SDRAM command stream for one chip select. Each request carries a byte address, a direction, a transfer size and the width of the memory port. Every access uses a closed page. The block opens the row, issues one column command per port-width beat, waits out the minimum row-active time, precharges all banks, and then waits out the precharge recovery before it reports completion.

Four programmable settings control the timing: the CAS latency, the activate-to-precharge minimum and the precharge recovery count are fields, and the activate-to-column gap is derived from the CAS latency. The block captures these settings when it accepts a request. It ignores the request and configuration inputs while an access is in progress. The host sees a `busy` level for the length of the access and a single `done` pulse once the access is fully retired.

Top module: `sdram_burst_seq`

## Requirements
- R1: Out of reset, and whenever no access is in progress, the block deselects the device. In that state `sd_cs_n`=1, {`sd_ras_n`,`sd_cas_n`,`sd_we_n`}=111, `sd_addr`=0, `sd_be`=0, `busy`=0 and `done`=0.
- R2: A request is taken on a rising edge where `req_valid`=1 and the block is idle. In the following cycle the block drives ACTV (`sd_cs_n`=0, command 011) and `busy` rises. `sd_addr` then carries the row, which is ((addr >> port_lg) >> 9) taken modulo 2^12.
- R3: Between ACTV and the first column command the block inserts cas_lat-1 NOP cycles (command 111, `sd_cs_n`=0). When `cfg_cas_lat` is 0 or 1, no NOP cycles are inserted.
- R4: The block issues the column commands on consecutive cycles: WRITE (100) when `req_write`=1 and READ (101) otherwise. The number of column commands is max(1, size_bytes / port_bytes). `req_size` codes 0,1,2,3 mean 1, 2, 4 and 16 bytes. `req_port` codes 0,1,2 mean an 8-, 16- or 32-bit port, and code 3 is treated as 32-bit.
- R5: The first column command carries column (addr >> port_lg) modulo 512. Each later column command carries the previous column plus one, wrapping within 9 bits. Address bit 10 stays 0 during column commands.
- R6: During column commands `sd_be` is all lanes of the port when the size is at least the port width. Otherwise it is the size's lane mask shifted to (addr mod port_bytes), rounded down to a multiple of size_bytes. `sd_be` is 0 in every other cycle.
- R7: PALL (command 010, `sd_addr` with only bit 10 set) appears exactly at cycle index max(gap+beats+1, `cfg_ras_min`), where ACTV is index 0. The cycles between the last column command and PALL are NOPs.
- R8: After PALL the block holds `cfg_rp` NOP cycles with `sd_cs_n`=0 and `busy`=1.
- R9: In the cycle after the recovery ends, `done`=1 for exactly one cycle, `busy`=0 and the device is deselected. A request presented in that cycle is accepted, so back-to-back accesses are possible.
- R10: Changes on `req_valid`, the request fields or the configuration fields while `busy`=1 have no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the transfer |
| req_size | input | 2 | Transfer size code (1/2/4/16 bytes) |
| req_port | input | 2 | Port width code (8/16/32 bits) |
| cfg_cas_lat | input | 2 | CAS latency; also sets the activate-to-column gap |
| cfg_ras_min | input | RAS_W | Minimum cycles from ACTV to PALL |
| cfg_rp | input | RP_W | Idle cycles after PALL |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | A_W | Row, column or precharge address |
| sd_be | output | 4 | Byte-lane enables during column commands |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The accepting edge defines index 0 as the cycle right after it. ACTV is due at index 0. Column command j is due at gap+1+j, PALL at P = max(gap+beats+1, ras_min), recovery NOPs at P+1..P+rp, and the `done` pulse at P+rp+1. The bench computes these indices arithmetically from the request and the settings. It samples every cycle of an access at the falling clock edge and compares the whole pin vector against the entry expected for that index. It sweeps every combination of CAS latency, four row-active minimums, four recovery counts, all sizes, all port widths and both directions. Each access is started in the `done` cycle of the one before, and some accesses toggle their inputs while busy.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
    localparam int LANES     = 4;
    localparam int MAX_BEATS = 16;
    localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
    localparam int PALL_BIT  = 10;

    // {ras_n, cas_n, we_n} with chip select low
    localparam logic [2:0] CMD_NOP  = 3'b111;
    localparam logic [2:0] CMD_ACT  = 3'b011;
    localparam logic [2:0] CMD_RD   = 3'b101;
    localparam logic [2:0] CMD_WR   = 3'b100;
    localparam logic [2:0] CMD_PALL = 3'b010;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ACT   = 3'd1,
        ST_GAP   = 3'd2,
        ST_COL   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_PRE   = 3'd5,
        ST_RECOV = 3'd6
    } seq_state_e;
endpackage

// File: rtl/sdram_xfer_plan.sv
// Splits a byte address into row and column phases and derives the beat
// count and byte-lane mask from the transfer size and port width codes.
module sdram_xfer_plan
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic [1:0]        port,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic [BEAT_W-1:0] beats,
    output logic [LANES-1:0]  mask
);
    logic [2:0]        tlg;
    logic [2:0]        plg;
    logic [ADDR_W-1:0] word;
    logic [1:0]        lane_bits;
    logic [1:0]        size_bits;
    logic [1:0]        off;
    logic [LANES-1:0]  tsz_lanes;
    logic [LANES-1:0]  port_lanes;

    always_comb begin
        case (size)
            2'd0:    tlg = 3'd0;
            2'd1:    tlg = 3'd1;
            2'd2:    tlg = 3'd2;
            default: tlg = 3'd4;
        endcase
        case (port)
            2'd0:    plg = 3'd0;
            2'd1:    plg = 3'd1;
            default: plg = 3'd2;
        endcase

        word = addr >> plg;
        col  = COL_W'(word);
        row  = ROW_W'(word >> COL_W);

        lane_bits  = (plg == 3'd2) ? 2'b11 : (plg == 3'd1) ? 2'b01 : 2'b00;
        size_bits  = (tlg == 3'd0) ? 2'b00 : (tlg == 3'd1) ? 2'b01 : 2'b11;
        off        = addr[1:0] & lane_bits & ~size_bits;
        tsz_lanes  = (tlg == 3'd0) ? 4'b0001 : 4'b0011;
        port_lanes = (plg == 3'd2) ? 4'b1111 : (plg == 3'd1) ? 4'b0011 : 4'b0001;

        if (tlg >= plg) begin
            beats = BEAT_W'(1) << (tlg - plg);
            mask  = port_lanes;
        end else begin
            beats = BEAT_W'(1);
            mask  = tsz_lanes << off;
        end
    end
endmodule

// File: rtl/sdram_wait_timer.sv
// Down counter: loaded with N, reports its final cycle N cycles later.
module sdram_wait_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 9,
    parameter int RAS_W  = 4,
    parameter int RP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_port,
    input  logic [1:0]        cfg_cas_lat,
    input  logic [RAS_W-1:0]  cfg_ras_min,
    input  logic [RP_W-1:0]   cfg_rp,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [((ROW_W > 11) ? ROW_W : 11)-1:0] sd_addr,
    output logic [LANES-1:0]  sd_be,
    output logic              busy,
    output logic              done
);
    localparam int A_W   = (ROW_W > 11) ? ROW_W : 11;
    localparam int CYC_W = RAS_W + 1;
    localparam int NK_W  = CYC_W + 1;
    localparam int TMR_W = (RP_W > 2) ? RP_W : 2;

    typedef struct packed {
        seq_state_e         st;
        logic               wr;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic [BEAT_W-1:0]  beats;
        logic [BEAT_W-1:0]  beat;
        logic [LANES-1:0]   mask;
        logic [1:0]         gap;
        logic [RAS_W-1:0]   ras;
        logic [RP_W-1:0]    rp;
        logic [CYC_W-1:0]   cyc;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;

    logic [ROW_W-1:0]  pl_row;
    logic [COL_W-1:0]  pl_col;
    logic [BEAT_W-1:0] pl_beats;
    logic [LANES-1:0]  pl_mask;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_last;
    logic [NK_W-1:0]   next_k;
    logic              pall_ok;
    logic [2:0]        cmd;
    logic [COL_W-1:0]  col_now;

    sdram_xfer_plan #(
        .ADDR_W (ADDR_W),
        .ROW_W  (ROW_W),
        .COL_W  (COL_W)
    ) u_plan (
        .addr  (req_addr),
        .size  (req_size),
        .port  (req_port),
        .row   (pl_row),
        .col   (pl_col),
        .beats (pl_beats),
        .mask  (pl_mask)
    );

    sdram_wait_timer #(
        .W (TMR_W)
    ) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    // next-state computation
    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        next_k   = NK_W'(s_q.cyc) + NK_W'(1);
        pall_ok  = (next_k >= NK_W'(s_q.ras));

        if (s_q.st != ST_IDLE && s_q.cyc != '1) begin
            s_d.cyc = s_q.cyc + CYC_W'(1);
        end

        case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.st    = ST_ACT;
                    s_d.wr    = req_write;
                    s_d.row   = pl_row;
                    s_d.col   = pl_col;
                    s_d.beats = pl_beats;
                    s_d.mask  = pl_mask;
                    s_d.beat  = '0;
                    s_d.gap   = (cfg_cas_lat <= 2'd1) ? 2'd0 : (cfg_cas_lat - 2'd1);
                    s_d.ras   = cfg_ras_min;
                    s_d.rp    = cfg_rp;
                    s_d.cyc   = '0;
                end
            end
            ST_ACT: begin
                if (s_q.gap != 2'd0) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(s_q.gap);
                    s_d.st   = ST_GAP;
                end else begin
                    s_d.st   = ST_COL;
                end
            end
            ST_GAP: begin
                if (tmr_last) s_d.st = ST_COL;
            end
            ST_COL: begin
                if (s_q.beat == s_q.beats - BEAT_W'(1)) begin
                    s_d.st = pall_ok ? ST_PRE : ST_HOLD;
                end else begin
                    s_d.beat = s_q.beat + BEAT_W'(1);
                end
            end
            ST_HOLD: begin
                if (pall_ok) s_d.st = ST_PRE;
            end
            ST_PRE: begin
                if (s_q.rp != '0) begin
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(s_q.rp);
                    s_d.st   = ST_RECOV;
                end else begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            ST_RECOV: begin
                if (tmr_last) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // pin decode from registered state
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        sd_be   = '0;
        col_now = s_q.col + COL_W'(s_q.beat);
        case (s_q.st)
            ST_ACT: begin
                cmd     = CMD_ACT;
                sd_addr = A_W'(s_q.row);
            end
            ST_COL: begin
                cmd     = s_q.wr ? CMD_WR : CMD_RD;
                sd_addr = A_W'(col_now);
                sd_be   = s_q.mask;
            end
            ST_PRE: begin
                cmd               = CMD_PALL;
                sd_addr[PALL_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cs_n = (s_q.st == ST_IDLE);
    assign busy    = (s_q.st != ST_IDLE);
    assign done    = s_q.done;
endmodule

// File: rtl/sdram_seq_checker.sv
module sdram_seq_checker #(
    parameter int A_W = 12
) (
    input logic           clk,
    input logic           rst_n,
    input logic           sd_cs_n,
    input logic           sd_ras_n,
    input logic           sd_cas_n,
    input logic           sd_we_n,
    input logic [A_W-1:0] sd_addr,
    input logic [3:0]     sd_be,
    input logic           busy,
    input logic           done
);
    logic [2:0] cmd;
    logic       is_col;
    assign cmd    = {sd_ras_n, sd_cas_n, sd_we_n};
    assign is_col = !sd_cs_n && (cmd == 3'b100 || cmd == 3'b101);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sd_cs_n && cmd == 3'b111 && sd_addr == '0 && sd_be == '0));

    a_r2_opens_with_act: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (!sd_cs_n && cmd == 3'b011));

    a_r4_col_has_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (sd_be != '0));

    a_r6_lanes_only_on_col: assert property (@(posedge clk) disable iff (!rst_n)
        !is_col |-> (sd_be == '0));

    a_r7_pall_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && cmd == 3'b010) |-> (sd_addr[10] && $countones(sd_addr) == 1));

    a_r8_no_act_after_pall: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && cmd == 3'b010) |=> (cmd != 3'b011));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));
endmodule

bind sdram_burst_seq sdram_seq_checker #(.A_W(A_W)) u_seq_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_addr  (sd_addr),
    .sd_be    (sd_be),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_sdram_burst_seq.sv
`timescale 1ns/1ps
module tb_sdram_burst_seq;
    localparam int ADDR_W = 24;
    localparam int A_W    = 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_size;
    logic [1:0]        req_port;
    logic [1:0]        cfg_cas_lat;
    logic [3:0]        cfg_ras_min;
    logic [2:0]        cfg_rp;
    logic              sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [A_W-1:0]    sd_addr;
    logic [3:0]        sd_be;
    logic              busy, done;
    logic [21:0]       obs;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    sdram_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_port(req_port),
        .cfg_cas_lat(cfg_cas_lat), .cfg_ras_min(cfg_ras_min), .cfg_rp(cfg_rp),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_be(sd_be), .busy(busy), .done(done)
    );

    assign obs = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_be, busy, done, sd_addr};

    function automatic logic [21:0] vec(input logic cs, input logic [2:0] c, input logic [3:0] be,
                                        input logic bz, input logic dn, input int a);
        return {cs, c, be, bz, dn, 12'(a)};
    endfunction

    task automatic check(input string tag, input logic [21:0] act, input logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_xfer(input bit wr, input int addr, input int size, input int port,
                           input int cas, input int ras, input int rp, input bit noisy);
        int tlg, plg, tb, pb, g, b, p, last, word, row, col0, off;
        logic [3:0]  mask;
        logic [21:0] e;
        string       tag;
        tlg  = (size == 3) ? 4 : size;
        plg  = (port >= 2) ? 2 : port;
        tb   = 1 << tlg;
        pb   = 1 << plg;
        g    = (cas <= 1) ? 0 : cas - 1;
        b    = (tb >= pb) ? tb / pb : 1;
        p    = g + b + 1;
        if (ras > p) p = ras;
        last = p + rp + 1;
        word = addr >> plg;
        row  = (word >> 9) & 12'hFFF;
        col0 = word & 511;
        if (tb >= pb) mask = 4'((1 << pb) - 1);
        else begin
            off  = ((addr % pb) / tb) * tb;
            mask = 4'(((1 << tb) - 1) << off);
        end
        req_write   = wr;
        req_addr    = 24'(addr);
        req_size    = 2'(size);
        req_port    = 2'(port);
        cfg_cas_lat = 2'(cas);
        cfg_ras_min = 4'(ras);
        cfg_rp      = 3'(rp);
        req_valid   = 1'b1;
        for (int k = 0; k <= last; k++) begin
            @(negedge clk);
            if (k == 0) begin
                tag = "R2 activate";
                e = vec(1'b0, 3'b011, 4'b0, 1'b1, 1'b0, row);
            end else if (k <= g) begin
                tag = "R3 gap";
                e = vec(1'b0, 3'b111, 4'b0, 1'b1, 1'b0, 0);
            end else if (k <= g + b) begin
                tag = "R4 R5 R6 column";
                e = vec(1'b0, wr ? 3'b100 : 3'b101, mask, 1'b1, 1'b0, (col0 + k - g - 1) & 511);
            end else if (k < p) begin
                tag = "R7 hold";
                e = vec(1'b0, 3'b111, 4'b0, 1'b1, 1'b0, 0);
            end else if (k == p) begin
                tag = "R7 precharge";
                e = vec(1'b0, 3'b010, 4'b0, 1'b1, 1'b0, 1 << 10);
            end else if (k <= p + rp) begin
                tag = "R8 recovery";
                e = vec(1'b0, 3'b111, 4'b0, 1'b1, 1'b0, 0);
            end else begin
                tag = "R9 done";
                e = vec(1'b1, 3'b111, 4'b0, 1'b0, 1'b1, 0);
            end
            if (noisy) tag = {tag, " R10"};
            check(tag, obs, e);
            if (k == 0) begin
                if (noisy) begin
                    req_write   = ~wr;
                    req_addr    = req_addr ^ 24'h5A5A5A;
                    req_size    = 2'(size + 1);
                    req_port    = 2'(port + 1);
                    cfg_cas_lat = 2'(cas + 1);
                    cfg_ras_min = 4'(ras + 5);
                    cfg_rp      = 3'(rp + 3);
                end else begin
                    req_valid = 1'b0;
                end
            end
            if (k == last - 1) req_valid = 1'b0;
        end
    endtask

    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int unsigned s;
        int          ras_v[4];
        int          rp_v[4];
        ras_v = '{0, 4, 9, 15};
        rp_v  = '{0, 1, 2, 7};
        s = 32'h1234567;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_size = '0; req_port = '0; cfg_cas_lat = '0; cfg_ras_min = '0; cfg_rp = '0;
        repeat (3) @(negedge clk);
        check("R1 in reset", obs, vec(1'b1, 3'b111, 4'b0, 1'b0, 1'b0, 0));
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 idle after reset", obs, vec(1'b1, 3'b111, 4'b0, 1'b0, 1'b0, 0));
        end

        for (int cas = 0; cas < 4; cas++)
            for (int ri = 0; ri < 4; ri++)
                for (int pi = 0; pi < 4; pi++)
                    for (int sz = 0; sz < 4; sz++)
                        for (int pt = 0; pt < 3; pt++)
                            for (int wr = 0; wr < 2; wr++) begin
                                s = s * 32'd1103515245 + 32'd12345;
                                do_xfer(wr[0], int'((s >> 4) & 32'hFFFFFF), sz, pt, cas,
                                        ras_v[ri], rp_v[pi], ((cas + ri + pi + sz + pt + wr) % 4) == 0);
                                if (s[30]) begin
                                    @(negedge clk);
                                    check("R1 idle between accesses", obs,
                                          vec(1'b1, 3'b111, 4'b0, 1'b0, 1'b0, 0));
                                end
                            end

        // column wrap on an 8-bit port, 16 beats from column 510 (R5)
        do_xfer(1'b1, (5 << 9) | 510, 3, 0, 2, 0, 1, 1'b0);
        // unsupported port code behaves as 32-bit (R4)
        do_xfer(1'b0, 24'h00ABC4, 3, 3, 3, 2, 0, 1'b0);
        @(negedge clk);
        check("R1 final idle", obs, vec(1'b1, 3'b111, 4'b0, 1'b0, 1'b0, 0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule